// File: doc/BRIEF.md
# Ordered Store Queue with Load Bypass

This block sits between one core's load/store port and a shared memory port, and it gives the core total-store-order semantics. Every store the core issues goes into a small queue first. The queue commits its entries to memory in the background through a write handshake, oldest first. Until an entry is written, no other agent on the memory side can see it.

Loads do not wait for the queue to empty. Each load address is compared against every queued entry. If any entries match, the youngest one returns its data straight from the queue. If none match, the load goes to the memory read port, even while commits are still stalled, and the read data comes back on the same response port. A flag on the response marks which path supplied the data.

A fence input holds both core ports until every queued store has been committed. It then raises an acknowledge so the core knows that all of its earlier stores are globally visible.

Top module: `tso_store_buffer`

## Requirements
- R1: Memory writes carry exactly the accepted stores, one per `mem_wr_valid && mem_wr_ready` handshake, in the order the core issued them; a store offered while `st_ready` is low is never written.
- R2: While `mem_wr_valid` is high and `mem_wr_ready` is low, the next cycle keeps `mem_wr_valid` high with `mem_wr_addr` and `mem_wr_data` unchanged.
- R3: A load whose full-word address equals a queued entry is answered from the queue: `rsp_valid` rises in the cycle after the load handshake, `rsp_fwd` is 1, and no memory read is issued for it.
- R4: When several queued entries match a load, the response carries the data of the most recently accepted one.
- R5: A load with no matching entry drives `mem_rd_valid`, even while the queue holds stalled entries. Its response arrives in the cycle after `mem_rd_rsp_valid` with that data and with `rsp_fwd` at 0.
- R6: When a store and a load are accepted in the same cycle, the load is treated as the older of the two and does not see that store's data.
- R7: The queue accepts DEPTH stores (8 by default) without a commit; with DEPTH entries held, `st_ready` is low.
- R8: While `fence_req` is high, `st_ready` and `ld_ready` are low; `fence_ack` is high exactly when `fence_req` is high and no store is queued.
- R9: After reset the queue is empty: `st_ready` is high, and `mem_wr_valid`, `rsp_valid` and `fence_ack` are low.
- R10: Only one memory read is in flight at a time; `ld_ready` stays low from a read handshake until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Core store request |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Core load request |
| ld_ready | output | 1 | Load accepted this cycle |
| ld_addr | input | AW | Load word address |
| rsp_valid | output | 1 | Load response valid (one cycle) |
| rsp_data | output | DW | Load response data |
| rsp_fwd | output | 1 | 1: data came from the queue, 0: from memory |
| mem_wr_valid | output | 1 | Commit write request (oldest entry) |
| mem_wr_ready | input | 1 | Memory accepts the commit write |
| mem_wr_addr | output | AW | Commit address |
| mem_wr_data | output | DW | Commit data |
| mem_rd_valid | output | 1 | Memory read request for a missed load |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | AW | Read address |
| mem_rd_rsp_valid | input | 1 | Memory read data valid |
| mem_rd_rsp_data | input | DW | Memory read data |
| fence_req | input | 1 | Fence request, held until acknowledged |
| fence_ack | output | 1 | All earlier stores committed |

## Verification
The assertions check the local rules on every cycle. They cover a stalled commit holding its address and data, a full or fenced queue refusing stores, a fence acknowledge appearing only with nothing left to commit, a matched load producing no memory read, and the timing of responses on both paths. Cross-transaction properties need the scenarios in the bench, which compares against a reference queue and memory model. These include commit order matching issue order, which of several matching entries supplies the data, a same-cycle store staying invisible to its companion load, and a miss load reading memory while commits are held back. An occupancy sweep covers every queue fill level against each target address.

// File: rtl/sfb_pkg.sv
// Shared definitions for the store queue.
// Assumes: imported by the load controller only; holds no parameters.
package sfb_pkg;
    // Load path state: idle, or waiting for one memory read response
    typedef enum logic [0:0] {
        LD_IDLE = 1'b0,
        LD_WAIT = 1'b1
    } ld_state_e;
endpackage

// File: rtl/sfb_ring.sv
// Circular entry storage for buffered stores.
// Presents the entries in age order (index 0 = oldest) so that the
// match logic needs no knowledge of the pointers.
// Assumes: DEPTH >= 2; push is never asserted when full, pop never when empty.
module sfb_ring #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [AW-1:0]                 push_addr,
    input  logic [DW-1:0]                 push_data,
    input  logic                          pop,
    output logic                          empty,
    output logic                          full,
    output logic [DEPTH-1:0]              age_valid,
    output logic [DEPTH-1:0][AW-1:0]      age_addr,
    output logic [DEPTH-1:0][DW-1:0]      age_data
);
    logic [AW-1:0] slot_addr [DEPTH];
    logic [DW-1:0] slot_data [DEPTH];
    logic [IW-1:0] head_q;
    logic [IW-1:0] tail_q;
    logic [CW-1:0] count_q;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= step(tail_q);
            if (pop)  head_q <= step(head_q);
            count_q <= count_q + CW'(push) - CW'(pop);
        end
    end

    // Entry payload write; storage needs no reset
    always_ff @(posedge clk) begin
        if (push) begin
            slot_addr[tail_q] <= push_addr;
            slot_data[tail_q] <= push_data;
        end
    end

    // Age-ordered view, rotating the slots so that index 0 is the head
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [IW:0] pos;
            pos = {1'b0, head_q} + (IW + 1)'(i);
            if (pos >= (IW + 1)'(DEPTH)) pos = pos - (IW + 1)'(DEPTH);
            age_valid[i] = (CW'(i) < count_q);
            age_addr[i]  = slot_addr[pos[IW-1:0]];
            age_data[i]  = slot_data[pos[IW-1:0]];
        end
    end

    assign empty = !age_valid[0];
    assign full  = age_valid[DEPTH-1];

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R1
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/sfb_match.sv
// Youngest-entry address match for loads.
// Scans the age-ordered entries from oldest to youngest, so a later
// match overrides an earlier one. Full-word compare, no partial overlap.
// Assumes: age_valid is a contiguous run starting at index 0.
module sfb_match #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic [DEPTH-1:0]              age_valid,
    input  logic [DEPTH-1:0][AW-1:0]      age_addr,
    input  logic [DEPTH-1:0][DW-1:0]      age_data,
    input  logic [AW-1:0]                 ld_addr,
    output logic                          hit,
    output logic [DW-1:0]                 hit_data
);
    // Priority scan: the last (youngest) matching entry wins
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (age_valid[i] && (age_addr[i] == ld_addr)) begin
                hit      = 1'b1;
                hit_data = age_data[i];
            end
        end
    end
endmodule

// File: rtl/sfb_load_ctl.sv
// Load path control: answers hits from the queue one cycle after
// acceptance and sends misses to memory with a single read in flight.
// Assumes: memory returns exactly one mem_rd_rsp_valid pulse per read.
module sfb_load_ctl #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          block,
    input  logic          ld_valid,
    output logic          ld_ready,
    input  logic          hit,
    input  logic [DW-1:0] hit_data,
    output logic          mem_rd_valid,
    input  logic          mem_rd_ready,
    input  logic          mem_rd_rsp_valid,
    input  logic [DW-1:0] mem_rd_rsp_data,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_fwd
);
    import sfb_pkg::*;

    ld_state_e state_q;
    logic      idle;

    // Acceptance: a hit needs only an idle path, a miss needs the read port
    always_comb begin
        idle         = (state_q == LD_IDLE);
        ld_ready     = !block && idle && (hit || mem_rd_ready);
        mem_rd_valid = ld_valid && !block && idle && !hit;
    end

    // Response register and read-in-flight state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LD_IDLE;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_fwd   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                LD_IDLE: begin
                    if (ld_valid && ld_ready) begin
                        if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= hit_data;
                            rsp_fwd   <= 1'b1;
                        end else begin
                            state_q <= LD_WAIT;
                        end
                    end
                end
                LD_WAIT: begin
                    if (mem_rd_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= mem_rd_rsp_data;
                        rsp_fwd   <= 1'b0;
                        state_q   <= LD_IDLE;
                    end
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    // R3
    fwd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready && hit) |=> (rsp_valid && rsp_fwd));

    // R5
    mem_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && mem_rd_rsp_valid) |=>
            (rsp_valid && !rsp_fwd && rsp_data == $past(mem_rd_rsp_data)));

    // R10
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |=> !ld_ready);
endmodule

// File: rtl/tso_store_buffer.sv
// Per-core store queue giving total-store-order behaviour.
// Stores are queued and committed oldest-first through the memory write
// port; loads bypass queued stores but see the youngest matching one.
// A fence holds both core ports until the queue is empty.
// Assumes: word addressing, full-word stores and loads.
module tso_store_buffer #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          ld_valid,
    output logic          ld_ready,
    input  logic [AW-1:0] ld_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_fwd,
    output logic          mem_wr_valid,
    input  logic          mem_wr_ready,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    output logic          mem_rd_valid,
    input  logic          mem_rd_ready,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_rsp_valid,
    input  logic [DW-1:0] mem_rd_rsp_data,
    input  logic          fence_req,
    output logic          fence_ack
);
    logic                     empty;
    logic                     full;
    logic                     push;
    logic                     pop;
    logic                     hit;
    logic [DW-1:0]            hit_data;
    logic [DEPTH-1:0]         age_valid;
    logic [DEPTH-1:0][AW-1:0] age_addr;
    logic [DEPTH-1:0][DW-1:0] age_data;

    // Core-side store acceptance and background commit of the oldest entry
    always_comb begin
        st_ready     = !full && !fence_req;
        push         = st_valid && st_ready;
        mem_wr_valid = !empty;
        mem_wr_addr  = age_addr[0];
        mem_wr_data  = age_data[0];
        pop          = mem_wr_valid && mem_wr_ready;
        mem_rd_addr  = ld_addr;
        fence_ack    = fence_req && empty;
    end

    sfb_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (pop),
        .empty     (empty),
        .full      (full),
        .age_valid (age_valid),
        .age_addr  (age_addr),
        .age_data  (age_data)
    );

    sfb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .age_valid (age_valid),
        .age_addr  (age_addr),
        .age_data  (age_data),
        .ld_addr   (ld_addr),
        .hit       (hit),
        .hit_data  (hit_data)
    );

    sfb_load_ctl #(.AW(AW), .DW(DW)) u_load (
        .clk              (clk),
        .rst_n            (rst_n),
        .block            (fence_req),
        .ld_valid         (ld_valid),
        .ld_ready         (ld_ready),
        .hit              (hit),
        .hit_data         (hit_data),
        .mem_rd_valid     (mem_rd_valid),
        .mem_rd_ready     (mem_rd_ready),
        .mem_rd_rsp_valid (mem_rd_rsp_valid),
        .mem_rd_rsp_data  (mem_rd_rsp_data),
        .rsp_valid        (rsp_valid),
        .rsp_data         (rsp_data),
        .rsp_fwd          (rsp_fwd)
    );

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R7
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !st_ready);

    // R8
    fence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_req |-> (!st_ready && !ld_ready));

    // R8
    fence_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_ack |-> !mem_wr_valid);

    // R3
    hit_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !mem_rd_valid);
endmodule

// File: tb/tso_store_buffer_tb.sv
module tso_store_buffer_tb;
    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          st_valid, st_ready;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic          ld_valid, ld_ready;
    logic [AW-1:0] ld_addr;
    logic          rsp_valid, rsp_fwd;
    logic [DW-1:0] rsp_data;
    logic          mem_wr_valid, mem_wr_ready;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic          mem_rd_valid, mem_rd_ready;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rd_rsp_valid;
    logic [DW-1:0] mem_rd_rsp_data;
    logic          fence_req, fence_ack;

    always #2 clk = ~clk;

    tso_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (.*);

    int checks = 0;
    int fails  = 0;

    // Reference state: issued-but-uncommitted stores, and memory
    logic [AW-1:0] q_addr [64];
    logic [DW-1:0] q_data [64];
    int            q_n = 0;
    logic [DW-1:0] mem_model [16];

    // Pending load expectation
    bit            exp_pending = 0;
    bit            exp_fwd     = 0;
    logic [DW-1:0] exp_data    = '0;
    string         exp_req     = "";
    int            rsp_seen    = 0;

    // Memory read responder state
    bit            rd_pend = 0;
    int            rd_wait = 0;
    logic [DW-1:0] rd_data = '0;
    bit            force_drain = 0;

    task automatic chk(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Reference monitor, sampled at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                // Load responses (R3 R4 R5)
                if (rsp_valid) begin
                    if (!exp_pending) chk("R5_unexpected_rsp", 1, 0);
                    else begin
                        chk(exp_req, rsp_data, exp_data);
                        chk(exp_req, DW'(rsp_fwd), DW'(exp_fwd));
                    end
                    exp_pending = 0;
                    rsp_seen++;
                end else if (exp_pending && exp_fwd) begin
                    chk("R3_late", 0, 1);
                    exp_pending = 0;
                    rsp_seen++;
                end
                // New load: compute its value before this cycle's store (R6)
                if (ld_valid && ld_ready) begin
                    int nm;
                    nm = 0;
                    exp_fwd = 0;
                    exp_data = mem_model[ld_addr[3:0]];
                    for (int k = 0; k < q_n; k++) begin
                        if (q_addr[k] == ld_addr) begin
                            exp_fwd = 1;
                            exp_data = q_data[k];
                            nm++;
                        end
                    end
                    exp_req = !exp_fwd ? "R5" : (nm > 1 ? "R4" : "R3");
                    exp_pending = 1;
                    chk(exp_fwd ? "R3_no_read" : "R5_read_issued",
                        DW'(mem_rd_valid), DW'(!exp_fwd));
                end
                if (mem_rd_valid && mem_rd_ready) begin
                    rd_pend = 1;
                    rd_wait = 2;
                    rd_data = mem_model[mem_rd_addr[3:0]];
                end
                // Commit writes must follow issue order (R1)
                if (mem_wr_valid && mem_wr_ready) begin
                    if (q_n == 0) chk("R1_spurious_write", 1, 0);
                    else begin
                        chk("R1_addr", mem_wr_addr, q_addr[0]);
                        chk("R1_data", mem_wr_data, q_data[0]);
                        mem_model[q_addr[0][3:0]] = q_data[0];
                        for (int k = 0; k < q_n - 1; k++) begin
                            q_addr[k] = q_addr[k+1];
                            q_data[k] = q_data[k+1];
                        end
                        q_n--;
                    end
                end
                if (st_valid && st_ready) begin
                    q_addr[q_n] = st_addr;
                    q_data[q_n] = st_data;
                    q_n++;
                end
            end
        end
    end

    // Memory read data returned three cycles after the read handshake
    initial begin
        mem_rd_rsp_valid = 0;
        mem_rd_rsp_data  = '0;
        forever begin
            @(posedge clk);
            #1;
            mem_rd_rsp_valid = 0;
            if (rd_pend) begin
                if (rd_wait == 0) begin
                    mem_rd_rsp_valid = 1;
                    mem_rd_rsp_data  = rd_data;
                    rd_pend = 0;
                end else rd_wait--;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    task automatic wait_ready_st();
        @(negedge clk);
        while (!st_ready) begin
            @(posedge clk);
            #1;
            if (force_drain) mem_wr_ready = 1;
            @(negedge clk);
        end
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk);
        #1;
        st_valid = 1; st_addr = a; st_data = d;
        wait_ready_st();
        @(posedge clk);
        #1;
        st_valid = 0;
    endtask

    task automatic wait_rsp(input int start);
        while (rsp_seen == start) @(negedge clk);
    endtask

    task automatic do_load(input logic [AW-1:0] a);
        int start;
        start = rsp_seen;
        @(posedge clk);
        #1;
        ld_valid = 1; ld_addr = a;
        @(negedge clk);
        while (!ld_ready) @(negedge clk);
        @(posedge clk);
        #1;
        ld_valid = 0;
        wait_rsp(start);
    endtask

    task automatic drain_all();
        @(posedge clk);
        #1;
        mem_wr_ready = 1;
        @(negedge clk);
        while (mem_wr_valid) @(negedge clk);
        chk("R1_all_committed", DW'(q_n), 0);
    endtask

    initial begin
        logic [15:0] lfsr;
        for (int a = 0; a < 16; a++) mem_model[a] = 32'hA5000000 + DW'(a * 17);
        rst_n = 0; st_valid = 0; st_addr = '0; st_data = '0;
        ld_valid = 0; ld_addr = '0; mem_wr_ready = 0; mem_rd_ready = 1;
        fence_req = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk("R9_st_ready", DW'(st_ready), 1);
        chk("R9_wr_valid", DW'(mem_wr_valid), 0);
        chk("R9_rsp_valid", DW'(rsp_valid), 0);
        chk("R9_fence_ack", DW'(fence_ack), 0);

        // R7 fill without commits; addresses repeat mod 3
        for (int i = 0; i < DEPTH; i++) do_store(AW'(i % 3), 32'h1000 + DW'(i));
        @(negedge clk);
        chk("R7_full_stall", DW'(st_ready), 0);
        // R2 stalled commit holds the oldest entry
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2_valid", DW'(mem_wr_valid), 1);
            chk("R2_addr", mem_wr_addr, 0);
            chk("R2_data", mem_wr_data, 32'h1000);
        end
        // R1 a store offered while full is dropped from the stream
        @(posedge clk);
        #1;
        st_valid = 1; st_addr = 5; st_data = 32'hDEAD;
        repeat (3) @(posedge clk);
        #1;
        st_valid = 0;
        // R4 youngest match: addr0 -> entry 6, addr1 -> 7, addr2 -> 5
        do_load(0);
        do_load(1);
        do_load(2);
        // R5 and R10 miss while commits are held back
        begin
            int start;
            start = rsp_seen;
            @(posedge clk);
            #1;
            ld_valid = 1; ld_addr = 9;
            @(negedge clk);
            while (!ld_ready) @(negedge clk);
            @(posedge clk);
            #1;
            ld_valid = 0;
            @(negedge clk);
            chk("R10_busy", DW'(ld_ready), 0);
            wait_rsp(start);
        end
        drain_all();
        chk("R1_dropped_not_written", mem_model[5], 32'hA5000000 + 5 * 17);

        // R6 same-cycle store and load to one address
        mem_wr_ready = 0;
        do_store(4, 32'h2000);
        begin
            int start;
            start = rsp_seen;
            @(posedge clk);
            #1;
            st_valid = 1; st_addr = 4; st_data = 32'h2001;
            ld_valid = 1; ld_addr = 4;
            @(negedge clk);
            chk("R6_st_ready", DW'(st_ready), 1);
            chk("R6_ld_ready", DW'(ld_ready), 1);
            @(posedge clk);
            #1;
            st_valid = 0; ld_valid = 0;
            wait_rsp(start);
        end
        do_load(4);
        drain_all();

        // R8 fence
        mem_wr_ready = 0;
        for (int i = 0; i < 3; i++) do_store(AW'(10 + i), 32'h3000 + DW'(i));
        @(posedge clk);
        #1;
        fence_req = 1;
        ld_addr = 11;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R8_no_ack", DW'(fence_ack), 0);
            chk("R8_st_block", DW'(st_ready), 0);
            chk("R8_ld_block", DW'(ld_ready), 0);
        end
        @(posedge clk);
        #1;
        mem_wr_ready = 1;
        @(negedge clk);
        while (!fence_ack) @(negedge clk);
        chk("R8_empty_at_ack", DW'(mem_wr_valid), 0);
        chk("R8_model_empty", DW'(q_n), 0);
        @(posedge clk);
        #1;
        fence_req = 0;

        // Occupancy sweep: every fill level against each target address (R3 R4 R5)
        for (int n = 0; n <= DEPTH; n++) begin
            @(posedge clk);
            #1;
            mem_wr_ready = 0;
            for (int k = 0; k < n; k++) do_store(AW'(k % 4), 32'h4000 + DW'(n * 16 + k));
            for (int t = 0; t < 5; t++) do_load(AW'(t));
            drain_all();
        end

        // Mixed traffic with irregular commit back-pressure
        force_drain = 1;
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(posedge clk);
            #1;
            mem_wr_ready = lfsr[5];
            if (lfsr[0]) do_store(AW'(lfsr[3:1]), 32'h5000 + DW'(i));
            else do_load(AW'(lfsr[3:1]));
        end
        drain_all();
        finish_run();
    end
endmodule